// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt events from two source groups and gives a processor one level request along with a vector address. The core group holds sources such as external pins, a timer overflow and a port change. The peripheral group holds the remaining devices. Every source has three bits: a sticky flag, an enable and a priority select. Software reaches these bits, and a control word, through a small register port.

A mode bit chooses between two schemes.

- **Flat scheme.** All sources share one vector. Core sources need the first global enable and their own enable. Peripheral sources also need the second global enable.
- **Priority scheme.** The first global enable gates the high level. The second global enable gates the low level. High requests take vector `VEC_HI` and low requests take vector `VEC_LO`.

The processor uses two handshake pulses. An acknowledge pulse accepts the presented request and closes the global enable of that level. A return pulse reopens the enable that the level being left had closed. A high request can therefore interrupt a low handler. A low request can never interrupt a high handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the following values hold.
  - All flags and enables read 0.
  - Every priority bit reads 1 (high).
  - The control word reads 0.
  - `irq_req` is 0.
- R2: The flags follow these update rules.
  - A one-cycle event pulse on a source input sets its flag, and the flag stays set until the bus writes it.
  - A bus write to a flag register loads the written value.
  - When an event and a bus write hit the same flag bit in the same cycle, the flag ends at 1.
- R3: With the mode bit at 0, priority bits have no effect.
  - A pending core flag requests when the first global enable and its own enable are 1.
  - A pending peripheral flag also needs the second global enable.
  - The vector is `VEC_HI` (default 0x000008).
- R4: With the mode bit at 1, a pending source whose priority bit is 1 requests when the first global enable and its own enable are 1. This applies to either group. The vector is `VEC_HI`.
- R5: With the mode bit at 1, a pending source whose priority bit is 0 requests only when both global enables and its own enable are 1. The vector is `VEC_LO` (default 0x000018).
- R6: When high and low sources qualify in the same cycle and no request is being presented, the high vector is presented.
- R7: The request output follows these timing rules.
  - `irq_req` rises on the second rising clock edge after the edge that samples a qualifying event.
  - While `irq_req` is 1 and no acknowledge arrives, `irq_vec` does not change.
  - `irq_req` falls one edge after the presented request stops qualifying.
- R8: An `irq_ack` pulse while `irq_req` is 1 has these effects.
  - On the `VEC_HI` vector, in either scheme, it clears the first global enable.
  - On the `VEC_LO` vector it clears the second global enable.
  - `irq_req` is 0 in the next cycle.
- R9: An `irq_ret` pulse restores one global enable.
  - If a high-level service is open, it sets the first global enable.
  - Otherwise, if a low-level service is open, it sets the second global enable.
  - With no service open, it sets the first global enable.
  - Exactly one global enable is restored per pulse.
- R10: While a low handler is open and the first global enable is 1, a high source is presented one cycle after the acknowledge. While the first global enable is 0, no low vector is presented.
- R11: A flag still set when its enable is restored by `irq_ret` raises `irq_req` again two edges after the return edge.
- R12: The register addresses are as follows, and `bus_rdata` shows the addressed register combinationally.
  - 0: control word. Bit 0 is the mode bit, bit 1 is the first global enable, bit 2 is the second global enable.
  - 1, 2, 3: core flags, core enables, core priorities.
  - 4, 5, 6: peripheral flags, peripheral enables, peripheral priorities.
  - Source `i` of a group is bit `i` of that group's registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_core | input | N_CORE | One-cycle event pulses of the core sources |
| evt_periph | input | N_PERIPH | One-cycle event pulses of the peripheral sources |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write register address |
| bus_wdata | input | DW | Write data |
| bus_raddr | input | 3 | Read register address |
| bus_rdata | output | DW | Read data of the addressed register |
| irq_req | output | 1 | Level interrupt request |
| irq_vec | output | ADDR_W | Vector of the presented request |
| irq_ack | input | 1 | Processor accepts the presented request |
| irq_ret | input | 1 | Processor returns from the current handler |

## Verification
There are three ways a corrupted internal state shows at the ports:

- **Global enable.** A wrong global enable shows within two cycles of the next event: `irq_req` stays 0 when it should rise, or it rises when it should stay 0.
- **Service record.** A lost or misrecorded service level stays hidden until the next `irq_ret`. At that point the wrong enable bit comes back in the control word, and a pending low source either raises `irq_req` or stays silent.
- **Presentation register.** A stale presentation register shows as a vector change during an unacknowledged request, or as a request that survives its own acknowledge by a cycle.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_CFLAG = 3'd1,
      RA_CEN   = 3'd2,
      RA_CPRI  = 3'd3,
      RA_PFLAG = 3'd4,
      RA_PEN   = 3'd5,
      RA_PPRI  = 3'd6
   } reg_addr_e;

   localparam int CTRL_W     = 3;
   localparam int CTRL_MODE  = 0;
   localparam int CTRL_G_HI  = 1;
   localparam int CTRL_G_LO  = 2;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/prio_irq_bank.sv
module prio_irq_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic         wr_flag,
   input  logic         wr_en,
   input  logic         wr_pri,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] flag,
   output logic [N-1:0] en,
   output logic [N-1:0] pri
);

   if (N < 1) begin : g_bad_n
      $error("prio_irq_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic f_q, e_q, p_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            f_q <= 1'b0;
            e_q <= 1'b0;
            p_q <= 1'b1;
         end else begin
            // a hardware event wins over a bus write in the same cycle
            f_q <= (wr_flag ? wdata[i] : f_q) | evt[i];
            if (wr_en)  e_q <= wdata[i];
            if (wr_pri) p_q <= wdata[i];
         end
      end

      assign flag[i] = f_q;
      assign en[i]   = e_q;
      assign pri[i]  = p_q;
   end

endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb #(
   parameter int NC = 6,
   parameter int NP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode,
   input  logic          g_hi,
   input  logic          g_lo,
   input  logic [NC-1:0] c_flag,
   input  logic [NC-1:0] c_en,
   input  logic [NC-1:0] c_pri,
   input  logic [NP-1:0] p_flag,
   input  logic [NP-1:0] p_en,
   input  logic [NP-1:0] p_pri,
   input  logic          ack,
   output logic          req,
   output logic          lvl_hi
);

   logic [NC-1:0] c_act;
   logic [NP-1:0] p_act;
   logic          any_c, any_p, any_hi, any_lo;
   logic          cand_flat, cand_hi, cand_lo, keep;
   logic          pres_v, pres_hi;

   always_comb begin
      c_act     = c_flag & c_en;
      p_act     = p_flag & p_en;
      any_c     = |c_act;
      any_p     = |p_act;
      any_hi    = (|(c_act & c_pri)) | (|(p_act & p_pri));
      any_lo    = (|(c_act & ~c_pri)) | (|(p_act & ~p_pri));
      cand_flat = g_hi & (any_c | (g_lo & any_p));
      cand_hi   = mode ? (g_hi & any_hi) : cand_flat;
      cand_lo   = mode & g_hi & g_lo & any_lo;
      keep      = pres_hi ? cand_hi : cand_lo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pres_v  <= 1'b0;
         pres_hi <= 1'b1;
      end else if (ack && pres_v) begin
         pres_v <= 1'b0;
      end else if (pres_v) begin
         if (!keep) pres_v <= 1'b0;
      end else if (cand_hi || cand_lo) begin
         pres_v  <= 1'b1;
         pres_hi <= cand_hi;
      end
   end

   assign req    = pres_v;
   assign lvl_hi = pres_hi;

endmodule

// File: rtl/prio_irq_ctx.sv
module prio_irq_ctx
   import prio_irq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              ack_hi,
   input  logic              ack_lo,
   input  logic              ret,
   output logic              mode,
   output logic              g_hi,
   output logic              g_lo
);

   logic act_hi, act_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= 1'b0;
      end else if (wr_ctrl) begin
         mode <= wdata[CTRL_MODE];
      end
   end

   // precedence: acknowledge, then return, then bus write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         g_hi   <= 1'b0;
         g_lo   <= 1'b0;
         act_hi <= 1'b0;
         act_lo <= 1'b0;
      end else if (ack_hi) begin
         g_hi   <= 1'b0;
         act_hi <= 1'b1;
      end else if (ack_lo) begin
         g_lo   <= 1'b0;
         act_lo <= 1'b1;
      end else if (ret) begin
         if (act_hi) begin
            g_hi   <= 1'b1;
            act_hi <= 1'b0;
         end else if (act_lo) begin
            g_lo   <= 1'b1;
            act_lo <= 1'b0;
         end else begin
            g_hi   <= 1'b1;
         end
      end else if (wr_ctrl) begin
         g_hi <= wdata[CTRL_G_HI];
         g_lo <= wdata[CTRL_G_LO];
      end
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter  int              N_CORE   = 6,
   parameter  int              N_PERIPH = 4,
   parameter  int              ADDR_W   = 21,
   parameter  logic [ADDR_W-1:0] VEC_HI = 21'h000008,
   parameter  logic [ADDR_W-1:0] VEC_LO = 21'h000018,
   localparam int              DW       = max3(N_CORE, N_PERIPH, CTRL_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_CORE-1:0]   evt_core,
   input  logic [N_PERIPH-1:0] evt_periph,
   input  logic                bus_wr,
   input  logic [2:0]          bus_waddr,
   input  logic [DW-1:0]       bus_wdata,
   input  logic [2:0]          bus_raddr,
   output logic [DW-1:0]       bus_rdata,
   output logic                irq_req,
   output logic [ADDR_W-1:0]   irq_vec,
   input  logic                irq_ack,
   input  logic                irq_ret
);

   if (N_CORE < 1 || N_PERIPH < 1) begin : g_bad_groups
      $error("prio_irq_ctrl: each group needs at least one source");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("prio_irq_ctrl: ADDR_W too small for the vectors");
   end
   if (VEC_HI == VEC_LO) begin : g_bad_vec
      $error("prio_irq_ctrl: the two vectors must differ");
   end

   logic [N_CORE-1:0]   c_flag, c_en, c_pri;
   logic [N_PERIPH-1:0] p_flag, p_en, p_pri;
   logic                mode_q, g_hi, g_lo;
   logic                lvl_hi, ack_hi, ack_lo;
   logic                wr_ctrl, wr_cf, wr_ce, wr_cp, wr_pf, wr_pe, wr_pp;

   always_comb begin
      wr_ctrl = bus_wr && (bus_waddr == RA_CTRL);
      wr_cf   = bus_wr && (bus_waddr == RA_CFLAG);
      wr_ce   = bus_wr && (bus_waddr == RA_CEN);
      wr_cp   = bus_wr && (bus_waddr == RA_CPRI);
      wr_pf   = bus_wr && (bus_waddr == RA_PFLAG);
      wr_pe   = bus_wr && (bus_waddr == RA_PEN);
      wr_pp   = bus_wr && (bus_waddr == RA_PPRI);
   end

   prio_irq_bank #(.N(N_CORE)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_core),
      .wr_flag (wr_cf),
      .wr_en   (wr_ce),
      .wr_pri  (wr_cp),
      .wdata   (bus_wdata[N_CORE-1:0]),
      .flag    (c_flag),
      .en      (c_en),
      .pri     (c_pri)
   );

   prio_irq_bank #(.N(N_PERIPH)) u_periph (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_periph),
      .wr_flag (wr_pf),
      .wr_en   (wr_pe),
      .wr_pri  (wr_pp),
      .wdata   (bus_wdata[N_PERIPH-1:0]),
      .flag    (p_flag),
      .en      (p_en),
      .pri     (p_pri)
   );

   prio_irq_arb #(.NC(N_CORE), .NP(N_PERIPH)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode_q),
      .g_hi   (g_hi),
      .g_lo   (g_lo),
      .c_flag (c_flag),
      .c_en   (c_en),
      .c_pri  (c_pri),
      .p_flag (p_flag),
      .p_en   (p_en),
      .p_pri  (p_pri),
      .ack    (irq_ack),
      .req    (irq_req),
      .lvl_hi (lvl_hi)
   );

   assign ack_hi = irq_ack && irq_req && lvl_hi;
   assign ack_lo = irq_ack && irq_req && !lvl_hi;

   prio_irq_ctx u_ctx (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wdata   (bus_wdata[CTRL_W-1:0]),
      .ack_hi  (ack_hi),
      .ack_lo  (ack_lo),
      .ret     (irq_ret),
      .mode    (mode_q),
      .g_hi    (g_hi),
      .g_lo    (g_lo)
   );

   assign irq_vec = lvl_hi ? VEC_HI : VEC_LO;

   always_comb begin
      bus_rdata = '0;
      case (bus_raddr)
         RA_CTRL: begin
            bus_rdata[CTRL_MODE] = mode_q;
            bus_rdata[CTRL_G_HI] = g_hi;
            bus_rdata[CTRL_G_LO] = g_lo;
         end
         RA_CFLAG: bus_rdata[N_CORE-1:0]   = c_flag;
         RA_CEN:   bus_rdata[N_CORE-1:0]   = c_en;
         RA_CPRI:  bus_rdata[N_CORE-1:0]   = c_pri;
         RA_PFLAG: bus_rdata[N_PERIPH-1:0] = p_flag;
         RA_PEN:   bus_rdata[N_PERIPH-1:0] = p_en;
         RA_PPRI:  bus_rdata[N_PERIPH-1:0] = p_pri;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int                NC     = 6,
   parameter int                AW     = 21,
   parameter logic [AW-1:0]     VEC_HI = 21'h000008,
   parameter logic [AW-1:0]     VEC_LO = 21'h000018
) (
   input logic          clk,
   input logic          rst_n,
   input logic          irq_req,
   input logic          irq_ack,
   input logic          irq_ret,
   input logic [AW-1:0] irq_vec,
   input logic [NC-1:0] evt_core,
   input logic [NC-1:0] c_flag,
   input logic          mode,
   input logic          g_hi,
   input logic          g_lo,
   input logic          act_hi
);

   p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_core != '0) |=> ((c_flag & $past(evt_core)) == $past(evt_core)));

   p_flat_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !mode && !$past(mode)) |-> (irq_vec == VEC_HI));

   p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !irq_ack) |=> (!irq_req || $stable(irq_vec)));

   p_ack_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && irq_vec == VEC_HI) |=> (!g_hi && !irq_req));

   p_ack_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req && irq_vec == VEC_LO) |=> (!g_lo && !irq_req));

   p_ret_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_ack && act_hi) |=> (g_hi && !act_hi));

   p_no_low_in_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(g_hi) |-> !(irq_req && irq_vec == VEC_LO));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
   .NC     (N_CORE),
   .AW     (ADDR_W),
   .VEC_HI (VEC_HI),
   .VEC_LO (VEC_LO)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_req  (irq_req),
   .irq_ack  (irq_ack),
   .irq_ret  (irq_ret),
   .irq_vec  (irq_vec),
   .evt_core (evt_core),
   .c_flag   (c_flag),
   .mode     (mode_q),
   .g_hi     (g_hi),
   .g_lo     (g_lo),
   .act_hi   (u_ctx.act_hi)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NC = 6;
   localparam int NP = 4;
   localparam int DW = 6;
   localparam int AW = 21;
   localparam logic [AW-1:0] VH = 21'h000008;
   localparam logic [AW-1:0] VL = 21'h000018;
   localparam logic [2:0] A_CTRL = 3'd0, A_CF = 3'd1, A_CE = 3'd2, A_CP = 3'd3;
   localparam logic [2:0] A_PF = 3'd4, A_PE = 3'd5, A_PP = 3'd6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] evt_core = '0;
   logic [NP-1:0] evt_periph = '0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_waddr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [2:0]    bus_raddr = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_req;
   logic [AW-1:0] irq_vec;
   logic          irq_ack = 1'b0;
   logic          irq_ret = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   prio_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .evt_core(evt_core), .evt_periph(evt_periph),
      .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
      .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .irq_req(irq_req),
      .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
      bus_raddr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic pulse(input int grp, input logic [DW-1:0] m);
      @(negedge clk);
      if (grp == 0) evt_core = m[NC-1:0]; else evt_periph = m[NP-1:0];
      @(negedge clk);
      evt_core = '0; evt_periph = '0;
   endtask

   task automatic do_ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic do_ret();
      @(negedge clk); irq_ret = 1'b1;
      @(negedge clk); irq_ret = 1'b0;
   endtask

   task automatic clean();
      wr(A_CTRL, '0);
      wr(A_CF, '0); wr(A_PF, '0);
      wr(A_CE, '0); wr(A_PE, '0);
      wr(A_CP, '1); wr(A_PP, '1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, addresses per R12
      rd(A_CTRL, v); chk("R1 ctrl", v, 0);
      rd(A_CF, v);   chk("R1 core flags", v, 0);
      rd(A_CE, v);   chk("R1 core en", v, 0);
      rd(A_CP, v);   chk("R1 R12 core pri", v, 6'h3F);
      rd(A_PF, v);   chk("R1 periph flags", v, 0);
      rd(A_PE, v);   chk("R1 periph en", v, 0);
      rd(A_PP, v);   chk("R1 R12 periph pri", v, 6'h0F);
      chk("R1 req", irq_req, 0);

      // R2 sticky flags and collision
      pulse(0, 6'h04);
      repeat (3) @(negedge clk);
      rd(A_CF, v); chk("R2 sticky", v, 6'h04);
      @(negedge clk);
      bus_wr = 1'b1; bus_waddr = A_CF; bus_wdata = '0; evt_core = 6'h08 | 6'h04;
      @(negedge clk);
      bus_wr = 1'b0; evt_core = '0;
      rd(A_CF, v); chk("R2 set wins over clear", v, 6'h0C);
      wr(A_CF, 6'h04);
      rd(A_CF, v); chk("R2 write clears", v, 6'h04);
      wr(A_PF, 6'h05);
      rd(A_PF, v); chk("R2 R12 periph write", v, 6'h05);
      chk("R2 no req while disabled", irq_req, 0);
      clean();

      // R3 R4 R5 sweep over every source and every enable/priority combination
      for (int m = 0; m < 2; m++)
         for (int grp = 0; grp < 2; grp++)
            for (int i = 0; i < ((grp == 0) ? NC : NP); i++)
               for (int ga = 0; ga < 2; ga++)
                  for (int gb = 0; gb < 2; gb++)
                     for (int en = 0; en < 2; en++)
                        for (int pr = 0; pr < 2; pr++) begin
                           logic [DW-1:0] one;
                           bit            exp_req;
                           logic [AW-1:0] exp_vec;
                           string         tag;
                           one = DW'(1) << i;
                           if (m == 0) begin
                              exp_req = (ga == 1) && (en == 1) && ((grp == 0) || (gb == 1));
                              exp_vec = VH;
                              tag = "R3 flat";
                           end else if (pr == 1) begin
                              exp_req = (ga == 1) && (en == 1);
                              exp_vec = VH;
                              tag = "R4 high";
                           end else begin
                              exp_req = (ga == 1) && (gb == 1) && (en == 1);
                              exp_vec = VL;
                              tag = "R5 low";
                           end
                           wr(A_CTRL, DW'({gb[0], ga[0], m[0]}));
                           wr((grp == 0) ? A_CE : A_PE, (en == 1) ? one : '0);
                           wr((grp == 0) ? A_CP : A_PP, (pr == 1) ? one : '0);
                           pulse(grp, one);
                           chk({tag, " R7 latency"}, irq_req, 0);
                           @(negedge clk);
                           chk({tag, " req"}, irq_req, exp_req);
                           if (exp_req) chk({tag, " vec"}, irq_vec, exp_vec);
                           clean();
                           chk({tag, " cleared"}, irq_req, 0);
                        end

      // R6 high chosen over low in the same cycle
      wr(A_CTRL, 6'h07); wr(A_CE, 6'h03); wr(A_CP, 6'h02);
      pulse(0, 6'h03);
      @(negedge clk);
      chk("R6 req", irq_req, 1);
      chk("R6 vec high", irq_vec, VH);
      clean();

      // R7 R8 R9 R10 R11 low handler preempted by high
      wr(A_PP, 6'h00); wr(A_PE, 6'h01);
      wr(A_CP, 6'h02); wr(A_CE, 6'h02);
      wr(A_CTRL, 6'h07);
      pulse(1, 6'h01);
      @(negedge clk);
      chk("R5 low presented", irq_vec, VL);
      pulse(0, 6'h02);
      chk("R7 vec held", irq_vec, VL);
      chk("R7 req held", irq_req, 1);
      do_ack();
      chk("R8 req drops after low ack", irq_req, 0);
      rd(A_CTRL, v); chk("R8 low ack clears second enable", v, 6'h03);
      @(negedge clk);
      chk("R10 high preempts", irq_req, 1);
      chk("R10 high vec", irq_vec, VH);
      do_ack();
      rd(A_CTRL, v); chk("R8 high ack clears first enable", v, 6'h01);
      @(negedge clk);
      chk("R10 low blocked in high", irq_req, 0);
      wr(A_CF, 6'h00);
      do_ret();
      rd(A_CTRL, v); chk("R9 only first enable restored", v, 6'h03);
      @(negedge clk); @(negedge clk);
      chk("R9 low still masked", irq_req, 0);
      do_ret();
      rd(A_CTRL, v); chk("R9 second enable restored", v, 6'h07);
      @(negedge clk);
      chk("R11 low re-raised", irq_req, 1);
      chk("R11 low vec", irq_vec, VL);
      clean();

      // R8 R9 R11 R7 flat scheme handshake
      wr(A_CTRL, 6'h02); wr(A_CE, 6'h01);
      pulse(0, 6'h01);
      @(negedge clk);
      chk("R3 flat req", irq_req, 1);
      do_ack();
      chk("R8 flat req drop", irq_req, 0);
      rd(A_CTRL, v); chk("R8 flat enable cleared", v, 6'h00);
      @(negedge clk);
      chk("R8 flat stays low", irq_req, 0);
      do_ret();
      rd(A_CTRL, v); chk("R9 flat enable set", v, 6'h02);
      @(negedge clk);
      chk("R11 flat re-raise", irq_req, 1);
      chk("R11 flat vec", irq_vec, VH);
      wr(A_CE, 6'h00);
      @(negedge clk);
      chk("R7 drop when unqualified", irq_req, 0);
      clean();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule